// File: doc/BRIEF.md
# Pipelined ADC Calibration Sequencer

This block is a synchronous controller between a host and an external pipelined analog-to-digital converter. It drives the converter's level-sensitive calibrate pin, its power-down pin and its active-low output enable, and it passes the converter's sample bus to the host with a valid strobe. The strobe is raised only for words that the converter produced in normal conversion, after the pipeline has refilled. All timing is counted in conversion-clock cycles.

A calibration is run once a programmable start-up wait has passed after every reset, and again whenever the host asks for one or the temperature-change flag is raised. A power-down is entered while the host holds its power-down request. Leaving power-down blanks data for a programmable wake-up time but does not recalibrate by itself. Calibration requests that arrive while the controller is calibrating or powered down are held and served as soon as that activity ends.

The state machine has six states. ST_PWRUP is the start-up wait after reset. ST_CAL_PULSE holds the calibrate pin high. ST_CAL_WAIT covers the calibration interval. ST_RUN is normal conversion. ST_PD is power-down. ST_WAKE is the blanking after power-down.

The transitions are as follows:
- **start**: ST_PWRUP goes to ST_CAL_PULSE when the start-up wait ends.
- **pulse_done**: ST_CAL_PULSE goes to ST_CAL_WAIT.
- **cal_done**: ST_CAL_WAIT goes to ST_RUN, or goes straight to ST_CAL_PULSE when a request is held (**recal**).
- **sleep**: ST_RUN goes to ST_PD on a power-down request.
- **cal_req**: ST_RUN goes to ST_CAL_PULSE on a calibration request.
- **release**: ST_PD goes to ST_WAKE when the power-down request drops.
- **awake**: ST_WAKE goes to ST_RUN, or goes to ST_CAL_PULSE when a request is held (**recal**).

Top module: `adc_cal_sequencer`

## Requirements
- R1: While reset is low, and after any reset, the outputs are cal=0, pd=0, oe_n=1, valid=0 and busy=1. The first calibrate pulse begins at the PWR_UP_WAIT-th rising edge after reset is released, so every reset is followed by a calibration.
- R2: The calibrate output stays high for exactly CAL_PULSE consecutive cycles. A CAL_PULSE below 3 is rejected at elaboration.
- R3: The calibrate pulse is followed by exactly CAL_CYCLES cycles during which cal=0, oe_n=1, busy=1 and valid=0.
- R4: In normal conversion, oe_n=0. data_valid_o first rises PIPE_LAT cycles after oe_n falls. While valid, data_o equals the adc_data_i value sampled at the previous rising edge.
- R5: In normal conversion with no power-down request, a high host_cal_req_i or temp_delta_i at a rising edge starts a calibrate pulse at that edge. At the same edge, oe_n rises and valid falls. Requests present at the edge where a pulse begins are consumed by that pulse.
- R6: A calibration request seen at any edge outside normal conversion (other than an edge where a pulse begins) is held. When the calibration interval or the wake-up time ends, the controller starts a new pulse directly, without oe_n going low.
- R7: A high host_pd_req_i at an edge in normal conversion raises pd and keeps it high while the request stays high. During that time oe_n=1, busy=1, valid=0 and cal=0. Power-down wins over a calibration request at the same edge; that calibration request is held.
- R8: pd falls at the edge where host_pd_req_i is seen low. For the next WAKE_CYCLES cycles oe_n=1 and busy=1. The controller then resumes conversion without calibrating unless a request is held, and valid follows after PIPE_LAT cycles.
- R9: A power-down request is not acted on during the start-up wait or calibration: pd stays low until normal conversion is reached.
- R10: busy_o is low only in normal conversion, and data_valid_o is never high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cal_req_i | input | 1 | Host request for a calibration |
| host_pd_req_i | input | 1 | Host power-down request, level |
| temp_delta_i | input | 1 | Temperature moved too far since last calibration |
| adc_data_i | input | DW | Sample bus from the converter |
| adc_cal_o | output | 1 | Converter calibrate pin |
| adc_pd_o | output | 1 | Converter power-down pin |
| adc_oe_n_o | output | 1 | Converter output enable, active low |
| data_o | output | DW | Registered sample word to the host |
| data_valid_o | output | 1 | data_o holds a valid conversion |
| busy_o | output | 1 | High outside normal conversion |

## Verification
The bench measures every interval edge to edge: the start-up wait, the pulse width, the calibration interval, the wake-up time and the pipeline refill. An off-by-one counter load would show up as a count one too long or too short. It pushes calibration requests into the pulse, into power-down and into the same edge as a power-down request. A design that dropped held requests would return to conversion instead of pulsing again; one that re-armed on a consumed request would pulse twice. It holds a power-down request through calibration and checks that a wake-up alone never recalibrates. A controller that obeyed power-down too early, or that tied recalibration to wake-up, would raise the wrong pin.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP     = 3'd0,
        ST_CAL_PULSE = 3'd1,
        ST_CAL_WAIT  = 3'd2,
        ST_RUN       = 3'd3,
        ST_PD        = 3'd4,
        ST_WAKE      = 3'd5
    } seq_state_e;

endpackage

// File: rtl/adc_cal_timer.sv
module adc_cal_timer #(
    parameter int unsigned     TW      = 8,
    parameter logic [TW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign zero_o = (cnt_q == '0);

    // R3: an expired interval stays expired until the next load
    p_timer_holds_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/adc_cal_req_latch.sv
module adc_cal_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req_i,
    input  logic temp_req_i,
    input  logic clear_i,
    output logic want_o
);

    logic pend_q;

    assign want_o = pend_q | host_req_i | temp_req_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (clear_i)
            pend_q <= 1'b0;
        else
            pend_q <= want_o;
    end

    // R6: a request not consumed at this edge is still pending afterwards
    p_req_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_req_i || temp_req_i) && !clear_i) |=> want_o);

endmodule

// File: rtl/adc_cal_valid_pipe.sv
module adc_cal_valid_pipe #(
    parameter int unsigned LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic valid_o
);

    logic [LAT-1:0] fill_q;

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) fill_q <= '0;
                else        fill_q <= run_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     fill_q <= '0;
                else if (run_i) fill_q <= {fill_q[LAT-2:0], 1'b1};
                else            fill_q <= '0;
            end
        end
    endgenerate

    assign valid_o = fill_q[LAT-1] & run_i;

    // R4: a valid word needs conversion to have been running on the previous cycle
    p_valid_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(run_i));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int unsigned DW          = 12,
    parameter int unsigned PWR_UP_WAIT = 200_000_000,
    parameter int unsigned CAL_PULSE   = 4,
    parameter int unsigned CAL_CYCLES  = 4000,
    parameter int unsigned WAKE_CYCLES = 16,
    parameter int unsigned PIPE_LAT    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cal_req_i,
    input  logic          host_pd_req_i,
    input  logic          temp_delta_i,
    input  logic [DW-1:0] adc_data_i,
    output logic          adc_cal_o,
    output logic          adc_pd_o,
    output logic          adc_oe_n_o,
    output logic [DW-1:0] data_o,
    output logic          data_valid_o,
    output logic          busy_o
);

    localparam int unsigned MAX_A = (PWR_UP_WAIT > CAL_CYCLES) ? PWR_UP_WAIT : CAL_CYCLES;
    localparam int unsigned MAX_B = (CAL_PULSE > WAKE_CYCLES) ? CAL_PULSE : WAKE_CYCLES;
    localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW    = $clog2(MAX_T + 1);

    localparam logic [TW-1:0] LD_PWRUP = TW'(PWR_UP_WAIT - 1);
    localparam logic [TW-1:0] LD_PULSE = TW'(CAL_PULSE - 1);
    localparam logic [TW-1:0] LD_CAL   = TW'(CAL_CYCLES - 1);
    localparam logic [TW-1:0] LD_WAKE  = TW'(WAKE_CYCLES - 1);

    generate
        if (CAL_PULSE < 3) begin : g_pulse_too_short
            $error("adc_cal_sequencer: CAL_PULSE must be at least 3 cycles");
        end
    endgenerate

    seq_state_e    state_q, state_d;
    logic          tmr_zero, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          want_cal, cal_start, in_run;
    logic [DW-1:0] data_q;

    adc_cal_timer #(.TW(TW), .RST_VAL(LD_PWRUP)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc_cal_req_latch u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req_i (host_cal_req_i),
        .temp_req_i (temp_delta_i),
        .clear_i    (cal_start),
        .want_o     (want_cal)
    );

    adc_cal_valid_pipe #(.LAT(PIPE_LAT)) u_vpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (in_run),
        .valid_o (data_valid_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:     if (tmr_zero) state_d = ST_CAL_PULSE;
            ST_CAL_PULSE: if (tmr_zero) state_d = ST_CAL_WAIT;
            ST_CAL_WAIT:  if (tmr_zero) state_d = want_cal ? ST_CAL_PULSE : ST_RUN;
            ST_RUN: begin
                if (host_pd_req_i)  state_d = ST_PD;
                else if (want_cal)  state_d = ST_CAL_PULSE;
            end
            ST_PD:        if (!host_pd_req_i) state_d = ST_WAKE;
            ST_WAKE:      if (tmr_zero) state_d = want_cal ? ST_CAL_PULSE : ST_RUN;
            default:      state_d = ST_PWRUP;
        endcase
    end

    assign tmr_load  = (state_d != state_q);
    assign cal_start = (state_d == ST_CAL_PULSE) && (state_q != ST_CAL_PULSE);

    always_comb begin
        case (state_d)
            ST_CAL_PULSE: tmr_val = LD_PULSE;
            ST_CAL_WAIT:  tmr_val = LD_CAL;
            ST_WAKE:      tmr_val = LD_WAKE;
            ST_PWRUP:     tmr_val = LD_PWRUP;
            default:      tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        adc_cal_o  = 1'b0;
        adc_pd_o   = 1'b0;
        adc_oe_n_o = 1'b1;
        busy_o     = 1'b1;
        in_run     = 1'b0;
        unique case (state_q)
            ST_PWRUP:     ;
            ST_CAL_PULSE: adc_cal_o = 1'b1;
            ST_CAL_WAIT:  ;
            ST_RUN: begin
                adc_oe_n_o = 1'b0;
                busy_o     = 1'b0;
                in_run     = 1'b1;
            end
            ST_PD:        adc_pd_o = 1'b1;
            ST_WAKE:      ;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= adc_data_i;
    end

    assign data_o = data_q;

    // R2: every calibrate pulse lasted at least three cycles
    p_cal_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cal_o) |-> ($past(adc_cal_o, 2) && $past(adc_cal_o, 3)));

    // R7: power-down keeps the converter outputs tri-stated and the block busy
    p_pd_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pd_o |-> (adc_oe_n_o && busy_o && !adc_cal_o));

    // R8: leaving power-down goes through wake-up blanking
    p_wake_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_pd_o) |-> (adc_oe_n_o && !data_valid_o));

    // R4: the first cycle of output enable never carries a valid word
    p_oe_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_oe_n_o) |-> !data_valid_o);

    // R10: valid data only in normal conversion
    p_valid_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (!busy_o && !adc_oe_n_o));

    // R9: power-down never overlaps a calibrate pulse
    p_no_pd_in_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_cal_o && adc_pd_o));

endmodule

// File: tb/tb_adc_cal_sequencer.sv
module tb_adc_cal_sequencer;

    localparam int DW  = 8;
    localparam int PW  = 20;
    localparam int CP  = 4;
    localparam int CC  = 40;
    localparam int WK  = 6;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_cal_req = 1'b0;
    logic          host_pd_req = 1'b0;
    logic          temp_delta = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          cal, pd, oe_n, valid, busy;
    logic [DW-1:0] data;
    logic [DW-1:0] exp_data = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_cal_sequencer #(
        .DW(DW), .PWR_UP_WAIT(PW), .CAL_PULSE(CP), .CAL_CYCLES(CC),
        .WAKE_CYCLES(WK), .PIPE_LAT(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_cal_req_i(host_cal_req),
        .host_pd_req_i(host_pd_req), .temp_delta_i(temp_delta),
        .adc_data_i(adc_data), .adc_cal_o(cal), .adc_pd_o(pd),
        .adc_oe_n_o(oe_n), .data_o(data), .data_valid_o(valid), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        exp_data = adc_data;
        adc_data = adc_data + DW'(37);
    endtask

    // starts at a negedge with cal high; ends in conversion with valid data
    task automatic cal_cycle(input string tag);
        int n;
        bit bad;
        n = 0;
        while (cal && n < 1000) begin n++; step(); end
        chk(n == CP, "R2", {tag, " pulse width"}, n, CP);
        n = 0; bad = 0;
        while (oe_n && n < 1000) begin
            if (cal || !busy || valid || pd) bad = 1;
            n++; step();
        end
        chk(n == CC, "R3", {tag, " calibration interval"}, n, CC);
        chk(!bad, "R3", {tag, " blanking during interval"}, bad, 0);
        n = 0; bad = 0;
        while (!valid && n < 1000) begin
            if (oe_n || busy) bad = 1;
            n++; step();
        end
        chk(n == LAT, "R4", {tag, " pipeline refill"}, n, LAT);
        chk(!bad, "R10", {tag, " busy low in conversion"}, bad, 0);
        for (int i = 0; i < 3; i++) begin
            chk(valid && data == exp_data, "R4", {tag, " data pass-through"}, data, exp_data);
            step();
        end
    endtask

    task automatic check_reset_outputs(input string tag);
        chk(!cal && !pd && oe_n && !valid && busy, "R1", {tag, " reset outputs"},
            {cal, pd, oe_n, valid, busy}, 5'b00101);
    endtask

    task automatic count_to_first_cal(input string tag);
        int n;
        bit bad;
        n = 0; bad = 0;
        while (!cal && n < 1000) begin
            if (!busy || !oe_n || pd) bad = 1;
            n++; step();
        end
        chk(n == PW, "R1", {tag, " start-up wait"}, n, PW);
        chk(!bad, "R1", {tag, " idle during wait"}, bad, 0);
    endtask

    task automatic t_power_up();
        host_pd_req = 1'b0;
        repeat (3) step();
        check_reset_outputs("power-up");
        rst_n = 1'b1;
        count_to_first_cal("power-up");
        cal_cycle("power-up");
    endtask

    task automatic t_host_cal();
        host_cal_req = 1'b1;
        step();
        host_cal_req = 1'b0;
        chk(cal && oe_n && !valid, "R5", "host request starts pulse", {cal, oe_n, valid}, 3'b110);
        cal_cycle("host");
    endtask

    task automatic t_temp_absorbed();
        bit bad;
        temp_delta = 1'b1;
        host_cal_req = 1'b1;
        step();
        temp_delta = 1'b0;
        host_cal_req = 1'b0;
        chk(cal && oe_n && !valid, "R5", "temperature flag starts pulse", {cal, oe_n, valid}, 3'b110);
        cal_cycle("temp");
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (cal || oe_n) bad = 1;
            step();
        end
        chk(!bad, "R5", "requests at pulse start consumed once", bad, 0);
    endtask

    task automatic t_latched_in_cal();
        int n;
        bit bad;
        host_cal_req = 1'b1;
        step();
        host_cal_req = 1'b0;
        step();
        host_cal_req = 1'b1;
        step();
        host_cal_req = 1'b0;
        while (cal) step();
        n = 0; bad = 0;
        while (!cal && n < 1000) begin
            if (!oe_n) bad = 1;
            n++; step();
        end
        chk(n == CC, "R6", "held request follows interval", n, CC);
        chk(!bad, "R6", "no conversion between calibrations", bad, 0);
        cal_cycle("held");
    endtask

    task automatic t_power_down();
        int n;
        bit bad;
        host_pd_req = 1'b1;
        step();
        chk(pd && oe_n && busy && !valid && !cal, "R7", "power-down entry",
            {pd, oe_n, busy, valid, cal}, 5'b11100);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            step();
            if (!pd || !oe_n || valid) bad = 1;
        end
        chk(!bad, "R7", "power-down held", bad, 0);
        host_pd_req = 1'b0;
        step();
        chk(!pd && oe_n && busy, "R8", "power-down release", {pd, oe_n, busy}, 3'b011);
        n = 0; bad = 0;
        while (oe_n && n < 1000) begin
            if (cal || valid) bad = 1;
            n++; step();
        end
        chk(n == WK, "R8", "wake-up blanking", n, WK);
        chk(!bad, "R8", "no pulse during wake-up", bad, 0);
        n = 0;
        while (!valid && n < 1000) begin n++; step(); end
        chk(n == LAT, "R8", "refill after wake-up", n, LAT);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (cal || !valid) bad = 1;
            step();
        end
        chk(!bad, "R8", "no recalibration after wake-up", bad, 0);
    endtask

    task automatic t_pd_priority();
        int n;
        bit bad;
        host_pd_req = 1'b1;
        host_cal_req = 1'b1;
        step();
        host_cal_req = 1'b0;
        chk(pd && !cal, "R7", "power-down wins over calibrate", {pd, cal}, 2'b10);
        repeat (4) step();
        host_pd_req = 1'b0;
        step();
        n = 0; bad = 0;
        while (!cal && n < 1000) begin
            if (!oe_n || pd) bad = 1;
            n++; step();
        end
        chk(n == WK, "R6", "request held across power-down", n, WK);
        chk(!bad, "R6", "no conversion before held pulse", bad, 0);
        cal_cycle("after-wake");
    endtask

    task automatic t_pd_during_cal();
        int n;
        bit bad;
        host_cal_req = 1'b1;
        step();
        host_cal_req = 1'b0;
        host_pd_req = 1'b1;
        n = 0; bad = 0;
        while (oe_n && n < 1000) begin
            if (pd) bad = 1;
            n++; step();
        end
        chk(!bad, "R9", "power-down ignored during calibration", bad, 0);
        chk(n == CP + CC, "R9", "calibration completes first", n, CP + CC);
        chk(!pd, "R9", "pd low on entering conversion", pd, 0);
        step();
        chk(pd, "R7", "power-down after calibration", pd, 1);
        host_pd_req = 1'b0;
        step();
        n = 0;
        while (!valid && n < 1000) begin n++; step(); end
        chk(n == WK + LAT, "R8", "wake-up then refill", n, WK + LAT);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_outputs("mid-run");
        step();
        step();
        rst_n = 1'b1;
        count_to_first_cal("mid-run");
        cal_cycle("after reset");
    endtask

    initial begin
        t_power_up();
        t_host_cal();
        t_temp_absorbed();
        t_latched_in_cal();
        t_power_down();
        t_pd_priority();
        t_pd_during_cal();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule